// File: doc/BRIEF.md
# Write-Guarded System Clock Control Registers

This block holds the software-visible state that steers a chip's clock tree. It has two control registers, a one-bit write-guard register and a main-clock divider code, all on a byte-wide bus with an address, a write strobe, write data and combinational read data. The register bits are decoded into level outputs. These outputs cover the clock-output pin source, gating of the peripheral clocks in wait mode, the enables and drive strength of the main and sub oscillators, the watchdog action and the system clock source.

Oscillators, drive circuits, the divider and the low-power sequencer all sit outside the block. The sequencer reports a stop-mode entry as a one-cycle pulse, together with a level that says whether the chip was running from a slow clock at that moment. Each oscillator reports its own stable flag. From these inputs the block applies four kinds of rule: the write guard, a watchdog-mode bit that cannot be cleared once set, bits that hardware forces, and refusal of unsafe clock-source changes.

Top module: `clkctl_regs`

## Requirements
- R1: After synchronous reset the first control register (address 0x06) reads 0x08, the second (0x07) reads 0x20, the guard register (0x0A) reads 0x00 and the divider register (0x0C) reads 0x03.
- R2: A write to 0x06 or 0x07 takes effect only while guard bit 0 is 1. Otherwise the register keeps its value. The guard register is always writable, stores only bit 0 and reads 0 in bits 7:1.
- R3: Bits 1:0 of register 0x06 drive the one-hot output `clkout_mode`: code 00 sets bit 0 (plain port), 01 sets bit 1 (fC), 10 sets bit 2 (f8) and 11 sets bit 3 (f32).
- R4: Bit 2 of register 0x06 appears on `wait_periph_stop`. A 1 requests that the f1, f8 and f32 peripheral clocks stop during wait mode.
- R5: Bit 6 of register 0x06 (watchdog action, 1 = reset) can be set by a write, and a later write of 0 leaves it at 1 until reset.
- R6: Bit 3 of register 0x06 (sub-oscillator high drive) becomes 1 on reset and after every stop-entry pulse. When a write lands in the same cycle as the pulse, the pulse wins for this bit.
- R7: Bit 5 of register 0x07 (main-oscillator high drive) becomes 1 after a stop-entry pulse when `slow_mode_at_stop` is 0. It keeps its value when that input is 1.
- R8: Register 0x0C stores the low 4 bits of each write and reads 0 in bits 7:4. From the cycle after register 0x06 bit 5 or register 0x07 bit 0 is 1, it holds the divide-by-8 code 0x03, and software writes to it are ignored.
- R9: A write that moves bit 7 of register 0x06 from 0 to 1 succeeds only if bit 4 was already 1 before the write and `sub_osc_stable` is 1. A refused write leaves bit 7 at 0 but still updates the other bits, so setting bits 4 and 7 together sets only bit 4.
- R10: A write that moves bit 7 of register 0x06 from 1 to 0 succeeds only if bit 5 was 0 before the write and `main_osc_stable` is 1. A refused write leaves bit 7 at 1 but still updates the other bits.
- R11: Register 0x07 stores only bits 0 and 5. All other bits read 0, whatever was written.
- R12: `bus_rdata` shows the addressed register in the same cycle, and reads 0x00 for any unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| stop_entry | input | 1 | One-cycle pulse when stop mode is entered |
| slow_mode_at_stop | input | 1 | 1 if the chip was in low-speed or low-power mode at stop entry |
| sub_osc_stable | input | 1 | Sub oscillator has settled |
| main_osc_stable | input | 1 | Main oscillator has settled |
| clkout_mode | output | 4 | One-hot clock-output pin source |
| wait_periph_stop | output | 1 | Stop peripheral clocks in wait mode |
| sub_drive_high | output | 1 | Sub oscillator high drive |
| sub_osc_enable | output | 1 | Sub oscillator enabled |
| main_osc_off | output | 1 | Main oscillator stopped |
| wdt_reset_mode | output | 1 | Watchdog triggers a reset instead of an interrupt |
| sysclk_from_sub | output | 1 | System clock taken from the sub oscillator |
| all_clocks_off | output | 1 | All clocks stopped |
| main_drive_high | output | 1 | Main oscillator high drive |
| main_div_code | output | 4 | Main clock divider code |

## Verification
Two pairs of functions can act in the same cycle. First, a stop-entry pulse can coincide with a software write to a drive-strength bit. The bench raises the pulse in the same cycle as a write that clears bit 3 of 0x06 or bit 5 of 0x07, and expects the forced 1 to be read back. Second, the divider can be forced while software writes it. The bench writes the divider while the main clock is stopped and expects 0x03, then writes it again once the main clock runs and expects the written value. Around these cases it sweeps every clock-output and wait-gating code and every combination of oscillator readiness for both source-switch directions.

// File: rtl/clkctl_pkg.sv
// Package: clkctl_pkg
// Shared bus map, reset values and bit positions for the clock control
// registers. Bit positions are fixed because the clock tree decodes them.
package clkctl_pkg;
    localparam int          BUS_W      = 8;
    localparam logic [7:0]  CTL0_RESET = 8'h08;
    localparam logic [7:0]  CTL1_RESET = 8'h20;
    localparam int          DIV_WIDTH  = 4;
    localparam logic [3:0]  DIV_BY8    = 4'h3;

    // register 0 bit positions
    localparam int C0_WAITSTOP = 2;
    localparam int C0_SUBDRV   = 3;
    localparam int C0_SUBEN    = 4;
    localparam int C0_MAINOFF  = 5;
    localparam int C0_WDT      = 6;
    localparam int C0_SYSSEL   = 7;
    // register 1 bit positions
    localparam int C1_ALLOFF   = 0;
    localparam int C1_MAINDRV  = 5;
endpackage

// File: rtl/clkctl_ctl0.sv
// Module: clkctl_ctl0
// First clock control register. It applies the sticky watchdog bit, the
// forced sub-drive bit on stop entry and the guarded clock-source switch.
// Assumes wr_en already includes the write-guard check.
module clkctl_ctl0
    import clkctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    input  logic             stop_evt,
    input  logic             sub_stable,
    input  logic             main_stable,
    output logic [BUS_W-1:0] q
);
    logic [BUS_W-1:0] nxt;

    // Next value: software fields, sticky bit, switch guard, stop force
    always_comb begin
        nxt = q;
        if (wr_en) begin
            nxt[C0_MAINOFF:0] = wdata[C0_MAINOFF:0];
            nxt[C0_WDT]       = q[C0_WDT] | wdata[C0_WDT];
            if (wdata[C0_SYSSEL] && !q[C0_SYSSEL])
                nxt[C0_SYSSEL] = q[C0_SUBEN] & sub_stable;
            else if (!wdata[C0_SYSSEL] && q[C0_SYSSEL])
                nxt[C0_SYSSEL] = ~(~q[C0_MAINOFF] & main_stable);
        end
        if (stop_evt)
            nxt[C0_SUBDRV] = 1'b1;
    end

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= CTL0_RESET;
        else        q <= nxt;
    end

    p_wdt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(q[C0_WDT]) |-> q[C0_WDT]);
    p_to_sub_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(q[C0_SYSSEL]) |-> $past(q[C0_SUBEN]) && $past(sub_stable));
    p_to_main_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(q[C0_SYSSEL]) |-> !$past(q[C0_MAINOFF]) && $past(main_stable));
    p_sub_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(stop_evt) |-> q[C0_SUBDRV]);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_en) && !$past(stop_evt) |-> $stable(q));
endmodule

// File: rtl/clkctl_ctl1.sv
// Module: clkctl_ctl1
// Second clock control register. It stores only the all-clocks-off bit and
// the main-drive bit, and forces main drive high on stop entry from fast
// modes. Assumes wr_en already includes the write-guard check.
module clkctl_ctl1
    import clkctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    input  logic             stop_evt,
    input  logic             slow_mode,
    output logic [BUS_W-1:0] q
);
    logic alloff_q;
    logic maindrv_q;

    // All-clocks-off bit: software only
    always_ff @(posedge clk) begin
        if (!rst_n)     alloff_q <= CTL1_RESET[C1_ALLOFF];
        else if (wr_en) alloff_q <= wdata[C1_ALLOFF];
    end

    // Main-drive bit: stop entry from a fast mode wins over software
    always_ff @(posedge clk) begin
        if (!rst_n)                    maindrv_q <= CTL1_RESET[C1_MAINDRV];
        else if (stop_evt && !slow_mode) maindrv_q <= 1'b1;
        else if (wr_en)                maindrv_q <= wdata[C1_MAINDRV];
    end

    // Assemble the visible byte with reserved bits at zero
    always_comb begin
        q             = '0;
        q[C1_ALLOFF]  = alloff_q;
        q[C1_MAINDRV] = maindrv_q;
    end

    p_main_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(stop_evt) && !$past(slow_mode) |-> maindrv_q);
    p_main_drive_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(stop_evt) && $past(slow_mode) && !$past(wr_en) |-> $stable(maindrv_q));
endmodule

// File: rtl/clkctl_div.sv
// Module: clkctl_div
// Main clock divider code register. While the main clock is stopped it is
// held at the forced code, and software writes are dropped.
module clkctl_div #(
    parameter int               DIV_W      = 4,
    parameter logic [DIV_W-1:0] FORCE_CODE = 3,
    parameter logic [DIV_W-1:0] RESET_CODE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wdata,
    input  logic             main_stopped,
    output logic [DIV_W-1:0] code
);
    // Forced code has priority over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)            code <= RESET_CODE;
        else if (main_stopped) code <= FORCE_CODE;
        else if (wr_en)        code <= wdata;
    end

    p_div_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(main_stopped) |-> code == FORCE_CODE);
endmodule

// File: rtl/clkctl_regs.sv
// Module: clkctl_regs (top)
// Byte-bus register block for system clock control. It decodes addresses,
// holds the write-guard bit, muxes read data combinationally and brings the
// control bits out as levels. Assumes at most one bus write per cycle.
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter logic [7:0] ADDR_CTL0  = 8'h06,
    parameter logic [7:0] ADDR_CTL1  = 8'h07,
    parameter logic [7:0] ADDR_GUARD = 8'h0A,
    parameter logic [7:0] ADDR_DIV   = 8'h0C,
    parameter int         DIV_W      = DIV_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             stop_entry,
    input  logic             slow_mode_at_stop,
    input  logic             sub_osc_stable,
    input  logic             main_osc_stable,
    output logic [3:0]       clkout_mode,
    output logic             wait_periph_stop,
    output logic             sub_drive_high,
    output logic             sub_osc_enable,
    output logic             main_osc_off,
    output logic             wdt_reset_mode,
    output logic             sysclk_from_sub,
    output logic             all_clocks_off,
    output logic             main_drive_high,
    output logic [DIV_W-1:0] main_div_code
);
    localparam int DIV_PAD = BUS_W - DIV_W;
    localparam int N_SRC   = 4;

    logic             guard_q;
    logic [BUS_W-1:0] ctl0_q;
    logic [BUS_W-1:0] ctl1_q;
    logic             we_ctl0, we_ctl1, we_guard, we_div;

    // Write strobes: control registers also need the guard bit
    always_comb begin
        we_ctl0  = bus_wr && (bus_addr == ADDR_CTL0) && guard_q;
        we_ctl1  = bus_wr && (bus_addr == ADDR_CTL1) && guard_q;
        we_guard = bus_wr && (bus_addr == ADDR_GUARD);
        we_div   = bus_wr && (bus_addr == ADDR_DIV);
    end

    // Guard register: only bit 0 is stored
    always_ff @(posedge clk) begin
        if (!rst_n)        guard_q <= 1'b0;
        else if (we_guard) guard_q <= bus_wdata[0];
    end

    clkctl_ctl0 u_ctl0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (we_ctl0),
        .wdata       (bus_wdata),
        .stop_evt    (stop_entry),
        .sub_stable  (sub_osc_stable),
        .main_stable (main_osc_stable),
        .q           (ctl0_q)
    );

    clkctl_ctl1 u_ctl1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (we_ctl1),
        .wdata     (bus_wdata),
        .stop_evt  (stop_entry),
        .slow_mode (slow_mode_at_stop),
        .q         (ctl1_q)
    );

    clkctl_div #(
        .DIV_W      (DIV_W),
        .FORCE_CODE (DIV_W'(DIV_BY8)),
        .RESET_CODE (DIV_W'(DIV_BY8))
    ) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (we_div),
        .wdata        (bus_wdata[DIV_W-1:0]),
        .main_stopped (ctl0_q[C0_MAINOFF] | ctl1_q[C1_ALLOFF]),
        .code         (main_div_code)
    );

    // One-hot decode of the clock-output source field
    for (genvar i = 0; i < N_SRC; i++) begin : g_clkout
        assign clkout_mode[i] = (ctl0_q[1:0] == 2'(i));
    end

    // Level outputs taken from the stored bits
    always_comb begin
        wait_periph_stop = ctl0_q[C0_WAITSTOP];
        sub_drive_high   = ctl0_q[C0_SUBDRV];
        sub_osc_enable   = ctl0_q[C0_SUBEN];
        main_osc_off     = ctl0_q[C0_MAINOFF];
        wdt_reset_mode   = ctl0_q[C0_WDT];
        sysclk_from_sub  = ctl0_q[C0_SYSSEL];
        all_clocks_off   = ctl1_q[C1_ALLOFF];
        main_drive_high  = ctl1_q[C1_MAINDRV];
    end

    // Combinational read mux, zero for unmapped addresses
    always_comb begin
        if (bus_addr == ADDR_CTL0)       bus_rdata = ctl0_q;
        else if (bus_addr == ADDR_CTL1)  bus_rdata = ctl1_q;
        else if (bus_addr == ADDR_GUARD) bus_rdata = {7'b0, guard_q};
        else if (bus_addr == ADDR_DIV)   bus_rdata = {{DIV_PAD{1'b0}}, main_div_code};
        else                             bus_rdata = '0;
    end

    p_clkout_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(clkout_mode));
    p_guard_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_wr && bus_addr == ADDR_CTL1 && !guard_q)
        && !$past(stop_entry) |-> $stable(ctl1_q));
endmodule

// File: tb/clkctl_regs_bench.sv
// Bench for clkctl_regs: drives the bus on falling edges, reads back
// combinationally and compares against values worked out from the
// requirements.
module clkctl_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A0 = 8'h06, A1 = 8'h07, AG = 8'h0A, AD = 8'h0C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       stop_entry = 1'b0;
    logic       slow_mode_at_stop = 1'b0;
    logic       sub_osc_stable = 1'b0;
    logic       main_osc_stable = 1'b0;
    logic [3:0] clkout_mode;
    logic       wait_periph_stop, sub_drive_high, sub_osc_enable, main_osc_off;
    logic       wdt_reset_mode, sysclk_from_sub, all_clocks_off, main_drive_high;
    logic [3:0] main_div_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkctl_regs u_clkctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_entry(stop_entry),
        .slow_mode_at_stop(slow_mode_at_stop), .sub_osc_stable(sub_osc_stable),
        .main_osc_stable(main_osc_stable), .clkout_mode(clkout_mode),
        .wait_periph_stop(wait_periph_stop), .sub_drive_high(sub_drive_high),
        .sub_osc_enable(sub_osc_enable), .main_osc_off(main_osc_off),
        .wdt_reset_mode(wdt_reset_mode), .sysclk_from_sub(sysclk_from_sub),
        .all_clocks_off(all_clocks_off), .main_drive_high(main_drive_high),
        .main_div_code(main_div_code)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // Write one byte, optionally together with a stop-entry pulse
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit stp);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; stop_entry = stp;
        @(negedge clk);
        bus_wr = 1'b0; stop_entry = 1'b0;
    endtask

    task automatic stop_pulse();
        @(negedge clk);
        stop_entry = 1'b1;
        @(negedge clk);
        stop_entry = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(A0, 8'h08, "R1 ctl0");
        rd(A1, 8'h20, "R1 ctl1");
        rd(AG, 8'h00, "R1 guard");
        rd(AD, 8'h03, "R1 div");
        // R2 writes blocked while the guard is clear
        wr(A0, 8'h00, 1'b0); rd(A0, 8'h08, "R2 ctl0 blocked");
        wr(A1, 8'h01, 1'b0); rd(A1, 8'h20, "R2 ctl1 blocked");
        wr(AG, 8'hFF, 1'b0); rd(AG, 8'h01, "R2 guard bit0 only");
        // R3 and R4 sweep of output source and wait gating
        for (int g = 0; g < 2; g++) begin
            for (int s = 0; s < 4; s++) begin
                wr(A0, 8'h08 | 8'(g << 2) | 8'(s), 1'b0);
                rd(A0, 8'h08 | 8'(g << 2) | 8'(s), "R3 ctl0 readback");
                check("R3 clkout_mode", {4'b0, clkout_mode}, 8'(1 << s));
                check("R4 wait_periph_stop", {7'b0, wait_periph_stop}, 8'(g));
            end
        end
        wr(A0, 8'h08, 1'b0);
        // R9 switch to the sub clock
        sub_osc_stable = 1'b1;
        wr(A0, 8'h98, 1'b0); rd(A0, 8'h18, "R9 enable and select together");
        sub_osc_stable = 1'b0;
        wr(A0, 8'h98, 1'b0); rd(A0, 8'h18, "R9 sub not stable");
        sub_osc_stable = 1'b1;
        wr(A0, 8'h98, 1'b0); rd(A0, 8'h98, "R9 switch accepted");
        check("R9 sysclk_from_sub", {7'b0, sysclk_from_sub}, 8'h01);
        // R8 divider writes while the main clock runs
        wr(AD, 8'h05, 1'b0); rd(AD, 8'h05, "R8 div write");
        wr(AD, 8'hF6, 1'b0); rd(AD, 8'h06, "R8 div upper bits");
        // R10 switch back to the main clock
        main_osc_stable = 1'b0;
        wr(A0, 8'h18, 1'b0); rd(A0, 8'h98, "R10 main not stable");
        main_osc_stable = 1'b1;
        wr(A0, 8'hB8, 1'b0); rd(A0, 8'hB8, "R10 stop main");
        check("R10 main_osc_off", {7'b0, main_osc_off}, 8'h01);
        @(negedge clk);
        rd(AD, 8'h03, "R8 forced by main stop");
        wr(AD, 8'h0A, 1'b0); rd(AD, 8'h03, "R8 write while stopped");
        wr(A0, 8'h18, 1'b0); rd(A0, 8'h98, "R10 main was off");
        wr(A0, 8'h18, 1'b0); rd(A0, 8'h18, "R10 switch accepted");
        check("R10 sysclk_from_sub", {7'b0, sysclk_from_sub}, 8'h00);
        wr(AD, 8'h0A, 1'b0); rd(AD, 8'h0A, "R8 write after restart");
        // R5 sticky watchdog bit
        wr(A0, 8'h58, 1'b0); rd(A0, 8'h58, "R5 set");
        wr(A0, 8'h18, 1'b0); rd(A0, 8'h58, "R5 clear ignored");
        check("R5 wdt_reset_mode", {7'b0, wdt_reset_mode}, 8'h01);
        // R11 reserved bits and R8 all-clocks-off force
        wr(A1, 8'hFF, 1'b0); rd(A1, 8'h21, "R11 reserved read zero");
        check("R8 all_clocks_off", {7'b0, all_clocks_off}, 8'h01);
        @(negedge clk);
        rd(AD, 8'h03, "R8 forced by all-off");
        wr(A1, 8'h00, 1'b0); rd(A1, 8'h00, "R11 clear");
        wr(AD, 8'h07, 1'b0); rd(AD, 8'h07, "R8 write after all-off");
        // R7 main drive on stop entry
        slow_mode_at_stop = 1'b1;
        stop_pulse(); rd(A1, 8'h00, "R7 kept from slow mode");
        slow_mode_at_stop = 1'b0;
        stop_pulse(); rd(A1, 8'h20, "R7 forced from fast mode");
        wr(A1, 8'h00, 1'b1); rd(A1, 8'h20, "R7 stop beats write");
        // R6 sub drive on stop entry
        wr(A0, 8'h50, 1'b1); rd(A0, 8'h58, "R6 stop beats write");
        wr(A0, 8'h50, 1'b0); rd(A0, 8'h50, "R6 cleared by write");
        check("R6 sub_drive_high", {7'b0, sub_drive_high}, 8'h00);
        slow_mode_at_stop = 1'b1;
        stop_pulse(); rd(A0, 8'h58, "R6 forced from slow mode");
        // R12 unmapped addresses
        rd(8'h00, 8'h00, "R12 unmapped 0x00");
        rd(8'h0B, 8'h00, "R12 unmapped 0x0B");
        // R2 guard cleared again blocks writes
        wr(AG, 8'h00, 1'b0);
        wr(A1, 8'h01, 1'b0); rd(A1, 8'h20, "R2 blocked after clear");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule